// File: doc/BRIEF.md
# Data Address Translation and Fault Capture

This block turns the virtual address of a load or store into a physical address. It uses a lookup result that a separate translation buffer supplies. In one combinational pass it does four things. It picks the privilege mode under which the access runs. It chooses one of three routes: a physical bypass, a direct superpage window, or a mapped page. It checks the read or write enables and the fault-on-read and fault-on-write flags of the page entry. It then reports a 3-bit fault code together with the physical address and an uncacheable hint.

When an access raises a translation fault, the block latches three things: the faulting virtual address, a packed status word and a formatted address pointing into the page table. It then locks all three. A later fault cannot overwrite them until software reads the address register. That read is signalled by a one-cycle strobe. Machine checks are reported through the fault code only and are not latched.

Top module: `dxl_translate`

## Requirements
- R1: The effective mode is `cur_mode` when `pc_privileged` is low. When `pc_privileged` is high, it is `alt_mode` if `req_alt` is set and kernel (0) otherwise. Modes are kernel 0, executive 1, supervisor 2 and user 3.
- R2: Fault codes are 0 none, 1 access violation, 2 fault, 3 miss, 4 page-table-entry miss and 5 machine check. Routes are checked in this priority order: physical, superpage, bad address, miss, permission. Machine check applies last, and only when no other fault was found.
- R3: A mapped read whose `tlb_rd_en` bit for the effective mode is clear gives code 1 with cause flags violation, plus fault-on-read if `tlb_fault_rd` is set. A permitted read with `tlb_fault_rd` set gives code 2 with fault-on-read alone.
- R4: A mapped write whose `tlb_wr_en` bit for the effective mode is clear gives code 2 with write and violation, plus fault-on-write if `tlb_fault_wr` is set. A permitted write with `tlb_fault_wr` set gives code 2 with write and fault-on-write.
- R5: On a lookup miss the code is 4 when `req_pte_fetch` is set and 3 otherwise. The cause flags are miss, plus write for stores.
- R6: An address whose bits 47:42 are not all equal to bit 42 is bad. It gives code 2 with bad-address and violation, plus write for stores.
- R7: With `superpage_en` set and address bits 42:41 equal to 2, the physical address is address bits 39:0 and no lookup is used. If `cur_mode` is not kernel, the result is code 1 with violation, plus write for stores.
- R8: A physical access passes address bits 43:0 through. Any route whose physical address has a bit above 39 set gives code 5, which is never latched. Bit 39 set on a fault-free access raises `uncached`.
- R9: A mapped access produces the physical address {`tlb_pfn`, address bits 12:0}.
- R10: The status word is {opcode[5:0] at 16:11, ra[4:0] at 10:6, causes at 5:0}. The cause bits are write 0, violation 1, fault-on-read 2, fault-on-write 3, miss 4 and bad address 5.
- R11: A latched fault stores the virtual address. It also stores a formatted address equal to `pt_base` OR (address bits 42:13 shifted left by 3).
- R12: While locked, the three registers keep their values. A `va_rd` pulse clears the lock at the next edge and does not capture a fault offered in that cycle. When unlocked, a fault is captured and locks even if `va_rd` is high in the same cycle.
- R13: After reset the lock is clear and all three registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | Access is a store |
| req_vaddr | input | 48 | Virtual address |
| req_physical | input | 1 | Bypass translation |
| req_alt | input | 1 | Access asks for the alternate mode |
| req_pte_fetch | input | 1 | Access fetches a page-table entry |
| pc_privileged | input | 1 | Current PC is in privileged code |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| superpage_en | input | 1 | Superpage window enabled |
| instr_opcode | input | 6 | Opcode of the current instruction |
| instr_ra | input | 5 | ra field of the current instruction |
| pt_base | input | 48 | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_pfn | input | 31 | Page frame number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fault_rd | input | 1 | Entry faults on read |
| tlb_fault_wr | input | 1 | Entry faults on write |
| va_rd | input | 1 | Software reads the fault address register |
| flt_code | output | 3 | Fault code of the current access |
| paddr | output | 44 | Physical address |
| uncached | output | 1 | Fault-free access targets uncacheable space |
| fault_va | output | 48 | Latched faulting address |
| mm_status | output | 17 | Latched status word |
| fault_va_form | output | 48 | Latched formatted address |
| regs_locked | output | 1 | Fault registers locked |

## Verification
The bench builds the block with its default widths: a 48-bit virtual address with 43 implemented bits, a 44-bit physical address with 40 implemented bits, and 8 KiB pages. With these widths the sign-extension check has upper bits to reject, so bad addresses can be tested. Physical bit 39 selects uncacheable space, and bits 43:40 can trigger a machine check. The superpage selector lands on bits 42:41, where hand-picked addresses reach it. The page-frame field is wide enough to drive a mapped access into both the uncacheable and the machine-check ranges.

// File: rtl/dxl_pkg.sv
// Shared types and constants for data address translation.
// Assumes a 2-bit privilege mode and a 6-bit cause field.
package dxl_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ACV      = 3'd1,
        FLT_FAULT    = 3'd2,
        FLT_MISS     = 3'd3,
        FLT_MISS_PTE = 3'd4,
        FLT_MCHK     = 3'd5
    } fault_e;

    localparam logic [1:0] MODE_KERNEL = 2'd0;

    localparam int CAUSE_W = 6;
    localparam int C_WR    = 0;
    localparam int C_ACV   = 1;
    localparam int C_FONR  = 2;
    localparam int C_FONW  = 3;
    localparam int C_MISS  = 4;
    localparam int C_BADVA = 5;

    localparam int OPC_W  = 6;
    localparam int RA_W   = 5;
    localparam int STAT_W = OPC_W + RA_W + CAUSE_W;

endpackage

// File: rtl/dxl_mode_sel.sv
// Effective privilege mode for a data access.
// Assumes the caller flags privileged code and alternate-mode requests.
module dxl_mode_sel (
    input  logic       pc_privileged,
    input  logic       req_alt,
    input  logic [1:0] cur_mode,
    input  logic [1:0] alt_mode,
    output logic [1:0] eff_mode
);
    import dxl_pkg::*;

    // Privileged code runs as kernel unless it asks for the alternate mode.
    always_comb begin
        if (pc_privileged)
            eff_mode = req_alt ? alt_mode : MODE_KERNEL;
        else
            eff_mode = cur_mode;
    end
endmodule

// File: rtl/dxl_classify.sv
// Route selection, permission checks and fault classification.
// Purely combinational; assumes VA_W >= PA_W and PA_W - PG_W pfn bits.
module dxl_classify #(
    parameter int VA_W      = 48,
    parameter int VA_IMPL_W = 43,
    parameter int PA_W      = 44,
    parameter int PA_IMPL_W = 40,
    parameter int PG_W      = 13,
    localparam int PFN_W    = PA_W - PG_W
) (
    input  logic              acc_write,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              acc_physical,
    input  logic              acc_pte_fetch,
    input  logic              sp_enable,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        eff_mode,
    input  logic              tlb_hit,
    input  logic [PFN_W-1:0]  tlb_pfn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fault_rd,
    input  logic              tlb_fault_wr,
    output dxl_pkg::fault_e   code,
    output logic [dxl_pkg::CAUSE_W-1:0] cause,
    output logic [PA_W-1:0]   paddr,
    output logic              uncached
);
    import dxl_pkg::*;

    logic va_ok;
    logic pa_hi_bad;
    logic is_super;
    fault_e code_pre;

    // Sign-extension check of the unimplemented virtual address bits.
    generate
        if (VA_W > VA_IMPL_W) begin : g_va_chk
            logic [VA_W-VA_IMPL_W:0] va_top;
            assign va_top = vaddr[VA_W-1:VA_IMPL_W-1];
            assign va_ok  = (&va_top) | ~(|va_top);
        end else begin : g_va_full
            assign va_ok = 1'b1;
        end
    endgenerate

    // Out-of-range physical address detection for machine checks.
    generate
        if (PA_W > PA_IMPL_W) begin : g_pa_chk
            assign pa_hi_bad = |paddr[PA_W-1:PA_IMPL_W];
        end else begin : g_pa_full
            assign pa_hi_bad = 1'b0;
        end
    endgenerate

    assign is_super = sp_enable && (vaddr[VA_IMPL_W-1 -: 2] == 2'b10);

    // Pick a route and classify the access before the machine check.
    always_comb begin
        code_pre = FLT_NONE;
        cause    = '0;
        paddr    = '0;
        if (acc_physical) begin
            paddr = vaddr[PA_W-1:0];
        end else if (is_super) begin
            paddr = PA_W'(vaddr[PA_IMPL_W-1:0]);
            if (cur_mode != MODE_KERNEL) begin
                code_pre     = FLT_ACV;
                cause[C_WR]  = acc_write;
                cause[C_ACV] = 1'b1;
            end
        end else if (!va_ok) begin
            code_pre       = FLT_FAULT;
            cause[C_WR]    = acc_write;
            cause[C_ACV]   = 1'b1;
            cause[C_BADVA] = 1'b1;
        end else if (!tlb_hit) begin
            code_pre      = acc_pte_fetch ? FLT_MISS_PTE : FLT_MISS;
            cause[C_WR]   = acc_write;
            cause[C_MISS] = 1'b1;
        end else begin
            paddr = {tlb_pfn, vaddr[PG_W-1:0]};
            if (acc_write) begin
                if (!tlb_wr_en[eff_mode]) begin
                    code_pre      = FLT_FAULT;
                    cause[C_WR]   = 1'b1;
                    cause[C_ACV]  = 1'b1;
                    cause[C_FONW] = tlb_fault_wr;
                end else if (tlb_fault_wr) begin
                    code_pre      = FLT_FAULT;
                    cause[C_WR]   = 1'b1;
                    cause[C_FONW] = 1'b1;
                end
            end else begin
                if (!tlb_rd_en[eff_mode]) begin
                    code_pre      = FLT_ACV;
                    cause[C_ACV]  = 1'b1;
                    cause[C_FONR] = tlb_fault_rd;
                end else if (tlb_fault_rd) begin
                    code_pre      = FLT_FAULT;
                    cause[C_FONR] = 1'b1;
                end
            end
        end
    end

    // Machine check only when translation itself found nothing wrong.
    always_comb begin
        code = code_pre;
        if (code_pre == FLT_NONE && pa_hi_bad)
            code = FLT_MCHK;
    end

    assign uncached = (code == FLT_NONE) && paddr[PA_IMPL_W-1];
endmodule

// File: rtl/dxl_fault_regs.sv
// Fault address, status and formatted-address registers with a read lock.
// Assumes take_fault is already qualified by a valid access.
module dxl_fault_regs #(
    parameter int VA_W      = 48,
    parameter int VA_IMPL_W = 43,
    parameter int PG_W      = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take_fault,
    input  logic                         va_rd,
    input  logic [VA_W-1:0]              vaddr,
    input  logic [VA_W-1:0]              pt_base,
    input  logic [dxl_pkg::OPC_W-1:0]    opcode,
    input  logic [dxl_pkg::RA_W-1:0]     ra,
    input  logic [dxl_pkg::CAUSE_W-1:0]  cause,
    output logic [VA_W-1:0]              fault_va,
    output logic [dxl_pkg::STAT_W-1:0]   status,
    output logic [VA_W-1:0]              va_form,
    output logic                         locked
);
    import dxl_pkg::*;

    localparam int VPN_W = VA_IMPL_W - PG_W;

    logic            capture;
    logic [VA_W-1:0] form_next;

    assign capture   = take_fault && !locked;
    assign form_next = pt_base | (VA_W'(vaddr[VA_IMPL_W-1:PG_W]) << 3);

    // Latch fault information once and hold it until the address is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_va <= '0;
            status   <= '0;
            va_form  <= '0;
            locked   <= 1'b0;
        end else if (capture) begin
            fault_va <= vaddr;
            status   <= {opcode, ra, cause};
            va_form  <= form_next;
            locked   <= 1'b1;
        end else if (va_rd) begin
            locked   <= 1'b0;
        end
    end

    logic unused_w;
    assign unused_w = ^VPN_W;
endmodule

// File: rtl/dxl_translate.sv
// Data address translation top: mode selection, classification and
// fault capture. Assumes lookup results arrive in the same cycle as the
// access and that va_rd is a one-cycle pulse from the register read path.
module dxl_translate #(
    parameter int VA_W      = 48,
    parameter int VA_IMPL_W = 43,
    parameter int PA_W      = 44,
    parameter int PA_IMPL_W = 40,
    parameter int PG_W      = 13,
    localparam int PFN_W    = PA_W - PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_physical,
    input  logic              req_alt,
    input  logic              req_pte_fetch,
    input  logic              pc_privileged,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              superpage_en,
    input  logic [5:0]        instr_opcode,
    input  logic [4:0]        instr_ra,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              tlb_hit,
    input  logic [PFN_W-1:0]  tlb_pfn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fault_rd,
    input  logic              tlb_fault_wr,
    input  logic              va_rd,
    output logic [2:0]        flt_code,
    output logic [PA_W-1:0]   paddr,
    output logic              uncached,
    output logic [VA_W-1:0]   fault_va,
    output logic [16:0]       mm_status,
    output logic [VA_W-1:0]   fault_va_form,
    output logic              regs_locked
);
    import dxl_pkg::*;

    logic [1:0]         eff_mode;
    fault_e             raw_code;
    logic [CAUSE_W-1:0] cause;
    logic               raw_unc;
    logic               take_fault;

    dxl_mode_sel u_mode (
        .pc_privileged (pc_privileged),
        .req_alt       (req_alt),
        .cur_mode      (cur_mode),
        .alt_mode      (alt_mode),
        .eff_mode      (eff_mode)
    );

    dxl_classify #(
        .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PA_W(PA_W),
        .PA_IMPL_W(PA_IMPL_W), .PG_W(PG_W)
    ) u_cls (
        .acc_write     (req_write),
        .vaddr         (req_vaddr),
        .acc_physical  (req_physical),
        .acc_pte_fetch (req_pte_fetch),
        .sp_enable     (superpage_en),
        .cur_mode      (cur_mode),
        .eff_mode      (eff_mode),
        .tlb_hit       (tlb_hit),
        .tlb_pfn       (tlb_pfn),
        .tlb_rd_en     (tlb_rd_en),
        .tlb_wr_en     (tlb_wr_en),
        .tlb_fault_rd  (tlb_fault_rd),
        .tlb_fault_wr  (tlb_fault_wr),
        .code          (raw_code),
        .cause         (cause),
        .paddr         (paddr),
        .uncached      (raw_unc)
    );

    // Qualify results with the valid strobe; machine checks are not latched.
    always_comb begin
        flt_code   = req_valid ? raw_code : FLT_NONE;
        uncached   = req_valid && raw_unc;
        take_fault = req_valid && (raw_code != FLT_NONE) && (raw_code != FLT_MCHK);
    end

    dxl_fault_regs #(
        .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PG_W(PG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_fault (take_fault),
        .va_rd      (va_rd),
        .vaddr      (req_vaddr),
        .pt_base    (pt_base),
        .opcode     (instr_opcode),
        .ra         (instr_ra),
        .cause      (cause),
        .fault_va   (fault_va),
        .status     (mm_status),
        .va_form    (fault_va_form),
        .locked     (regs_locked)
    );
endmodule

// File: rtl/dxl_checker.sv
// Temporal checks on the fault capture and lock behaviour, bound to the top.
module dxl_checker #(
    parameter int VA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [5:0]      instr_opcode,
    input logic [4:0]      instr_ra,
    input logic            va_rd,
    input logic [2:0]      flt_code,
    input logic [VA_W-1:0] fault_va,
    input logic [16:0]     mm_status,
    input logic [VA_W-1:0] fault_va_form,
    input logic            regs_locked
);
    logic latchable;
    assign latchable = req_valid && (flt_code >= 3'd1) && (flt_code <= 3'd4);

    AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        regs_locked && !va_rd |=> $stable(fault_va) && $stable(mm_status) && $stable(fault_va_form)); // R12

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        regs_locked && va_rd |=> !regs_locked); // R12

    AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        latchable && !regs_locked |=> regs_locked && fault_va == $past(req_vaddr)); // R11

    AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        latchable && !regs_locked |=> mm_status[16:11] == $past(instr_opcode) && mm_status[10:6] == $past(instr_ra)); // R10

    AST_MCHK_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_locked && !latchable |=> !regs_locked); // R8
endmodule

bind dxl_translate dxl_checker #(.VA_W(VA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .instr_opcode(instr_opcode), .instr_ra(instr_ra), .va_rd(va_rd),
    .flt_code(flt_code), .fault_va(fault_va), .mm_status(mm_status),
    .fault_va_form(fault_va_form), .regs_locked(regs_locked)
);

// File: tb/tb_dxl_translate.sv
`timescale 1ns/1ps
module tb_dxl_translate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_physical = 0, req_alt = 0, req_pte_fetch = 0;
    logic [47:0] req_vaddr = '0;
    logic        pc_privileged = 0, superpage_en = 1;
    logic [1:0]  cur_mode = 0, alt_mode = 0;
    logic [5:0]  instr_opcode = 6'h2C;
    logic [4:0]  instr_ra = 5'h0B;
    logic [47:0] pt_base = 48'h0002_0000_0000;
    logic        tlb_hit = 0, tlb_fault_rd = 0, tlb_fault_wr = 0, va_rd = 0;
    logic [30:0] tlb_pfn = '0;
    logic [3:0]  tlb_rd_en = 0, tlb_wr_en = 0;
    logic [2:0]  flt_code;
    logic [43:0] paddr;
    logic        uncached, regs_locked;
    logic [47:0] fault_va, fault_va_form;
    logic [16:0] mm_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dxl_translate dut (.*);

    typedef struct packed {
        logic        wr;
        logic [47:0] va;
        logic        phys, alt, ptef, priv;
        logic [1:0]  cm, am;
        logic        sp, hit;
        logic [30:0] pfn;
        logic [3:0]  rde, wre;
        logic        fr, fw;
        logic [2:0]  code;
        logic [5:0]  cause;
        logic [43:0] pa;
        logic        unc;
    } vec_t;

    localparam logic [47:0] VA_A = 48'h0000_1234_5678;
    localparam logic [43:0] PA_A = 44'h000_0157_9678;
    localparam logic [47:0] VA_S = 48'hFC00_1234_5000;
    localparam logic [47:0] VA_B = 48'h8000_0000_0000;
    localparam logic [30:0] PF   = 31'h0000_0ABC;
    localparam int NV = 23;

    // wr va phys alt ptef priv cm am sp hit pfn rde wre fr fw code cause pa unc
    localparam vec_t VECS [NV] = '{
        '{0, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h8,4'h0, 0,0, 3'd0, 6'h00, PA_A, 0}, // R3 R9
        '{1, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h0,4'h8, 0,0, 3'd0, 6'h00, PA_A, 0}, // R4 R9
        '{0, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h1,4'h0, 0,0, 3'd1, 6'h02, 44'h0, 0}, // R3
        '{0, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h1,4'h0, 1,0, 3'd1, 6'h06, 44'h0, 0}, // R3
        '{0, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h8,4'h0, 1,0, 3'd2, 6'h04, 44'h0, 0}, // R3
        '{1, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h0,4'h1, 0,1, 3'd2, 6'h0B, 44'h0, 0}, // R4
        '{1, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h0,4'h1, 0,0, 3'd2, 6'h03, 44'h0, 0}, // R4
        '{1, VA_A, 0,0,0,0, 2'd3,2'd0, 1,1, PF, 4'h0,4'h8, 0,1, 3'd2, 6'h09, 44'h0, 0}, // R4
        '{0, VA_A, 0,0,0,0, 2'd3,2'd0, 1,0, PF, 4'hF,4'hF, 0,0, 3'd3, 6'h10, 44'h0, 0}, // R5
        '{1, VA_A, 0,0,1,0, 2'd3,2'd0, 1,0, PF, 4'hF,4'hF, 0,0, 3'd4, 6'h11, 44'h0, 0}, // R5
        '{0, VA_B, 0,0,0,0, 2'd0,2'd0, 1,1, PF, 4'hF,4'hF, 0,0, 3'd2, 6'h22, 44'h0, 0}, // R6
        '{1, VA_B, 0,0,0,0, 2'd0,2'd0, 1,1, PF, 4'hF,4'hF, 0,0, 3'd2, 6'h23, 44'h0, 0}, // R6
        '{0, VA_A, 0,0,0,1, 2'd3,2'd0, 1,1, PF, 4'h1,4'h0, 0,0, 3'd0, 6'h00, PA_A, 0}, // R1
        '{0, VA_A, 0,1,0,1, 2'd0,2'd3, 1,1, PF, 4'h1,4'h0, 0,0, 3'd1, 6'h02, 44'h0, 0}, // R1
        '{0, VA_A, 0,1,0,1, 2'd0,2'd2, 1,1, PF, 4'h4,4'h0, 0,0, 3'd0, 6'h00, PA_A, 0}, // R1
        '{0, VA_A, 0,1,0,0, 2'd2,2'd0, 1,1, PF, 4'h4,4'h0, 0,0, 3'd0, 6'h00, PA_A, 0}, // R1
        '{0, VA_S, 0,0,0,0, 2'd0,2'd0, 1,0, PF, 4'h0,4'h0, 0,0, 3'd0, 6'h00, 44'h000_1234_5000, 0}, // R7
        '{1, VA_S, 0,0,0,0, 2'd3,2'd0, 1,0, PF, 4'h0,4'h0, 0,0, 3'd1, 6'h03, 44'h0, 0}, // R7
        '{0, VA_S, 0,0,0,0, 2'd0,2'd0, 0,0, PF, 4'h0,4'h0, 0,0, 3'd3, 6'h10, 44'h0, 0}, // R7
        '{0, 48'h0080_0000_1000, 1,0,0,0, 2'd3,2'd0, 1,0, PF, 4'h0,4'h0, 0,0, 3'd0, 6'h00, 44'h080_0000_1000, 1}, // R8
        '{0, 48'h0100_0000_0000, 1,0,0,0, 2'd3,2'd0, 1,0, PF, 4'h0,4'h0, 0,0, 3'd5, 6'h00, 44'h100_0000_0000, 0}, // R8
        '{0, VA_A, 0,0,0,0, 2'd0,2'd0, 1,1, 31'h0800_0000, 4'h1,4'h0, 0,0, 3'd5, 6'h00, 44'h100_0000_1678, 0}, // R8
        '{0, VA_A, 0,0,0,0, 2'd0,2'd0, 1,1, 31'h0400_0ABC, 4'h1,4'h0, 0,0, 3'd0, 6'h00, 44'h080_0157_9678, 1}  // R8 R9
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1; req_write = v.wr; req_vaddr = v.va; req_physical = v.phys;
        req_alt = v.alt; req_pte_fetch = v.ptef; pc_privileged = v.priv;
        cur_mode = v.cm; alt_mode = v.am; superpage_en = v.sp; tlb_hit = v.hit;
        tlb_pfn = v.pfn; tlb_rd_en = v.rde; tlb_wr_en = v.wre;
        tlb_fault_rd = v.fr; tlb_fault_wr = v.fw;
    endtask

    function automatic logic [47:0] form_of(input logic [47:0] va);
        return pt_base | ({18'b0, va[42:13]} << 3); // R11
    endfunction

    task automatic release_lock();
        @(negedge clk); req_valid = 0; va_rd = 1;
        @(negedge clk); va_rd = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 locked", 64'(regs_locked), 64'h0);
        chk("R13 fault_va", 64'(fault_va), 64'h0);
        chk("R13 status", 64'(mm_status), 64'h0);
        chk("R13 form", 64'(fault_va_form), 64'h0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R1..R11
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            #1;
            chk($sformatf("R2 code row %0d", i), 64'(flt_code), 64'(VECS[i].code));
            if (VECS[i].code == 3'd0 || VECS[i].code == 3'd5) begin
                chk($sformatf("R9 paddr row %0d", i), 64'(paddr), 64'(VECS[i].pa));
                chk($sformatf("R8 uncached row %0d", i), 64'(uncached), 64'(VECS[i].unc));
            end
            @(negedge clk);
            req_valid = 0;
            if (VECS[i].code >= 3'd1 && VECS[i].code <= 3'd4) begin
                chk($sformatf("R12 lock row %0d", i), 64'(regs_locked), 64'h1);
                chk($sformatf("R10 status row %0d", i), 64'(mm_status),
                    64'({instr_opcode, instr_ra, VECS[i].cause}));
                chk($sformatf("R11 va row %0d", i), 64'(fault_va), 64'(VECS[i].va));
                chk($sformatf("R11 form row %0d", i), 64'(fault_va_form), 64'(form_of(VECS[i].va)));
                va_rd = 1;
                @(negedge clk); va_rd = 0;
            end
            chk($sformatf("R12 unlocked row %0d", i), 64'(regs_locked), 64'h0);
        end

        // R12: a second fault while locked does not overwrite
        drive(VECS[2]);
        @(negedge clk);
        drive(VECS[11]); instr_opcode = 6'h11;
        @(negedge clk);
        req_valid = 0;
        chk("R12 hold va", 64'(fault_va), 64'(VA_A));
        chk("R12 hold status", 64'(mm_status), 64'({6'h2C, 5'h0B, 6'h02}));
        // R12: read while a fault is offered releases and does not capture
        drive(VECS[11]); va_rd = 1;
        @(negedge clk);
        req_valid = 0; va_rd = 0;
        chk("R12 release", 64'(regs_locked), 64'h0);
        chk("R12 no capture on release", 64'(fault_va), 64'(VA_A));
        // R12: unlocked fault with read in the same cycle is captured
        drive(VECS[11]); va_rd = 1;
        @(negedge clk);
        req_valid = 0; va_rd = 0;
        chk("R12 capture wins", 64'(regs_locked), 64'h1);
        chk("R12 capture va", 64'(fault_va), 64'(VA_B));
        chk("R10 new opcode", 64'(mm_status[16:11]), 64'h11);
        release_lock();

        // R8: machine check after unlock leaves registers alone
        drive(VECS[20]);
        @(negedge clk);
        req_valid = 0;
        chk("R8 mchk not latched", 64'(regs_locked), 64'h0);
        chk("R8 mchk va kept", 64'(fault_va), 64'(VA_B));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule